// File: doc/BRIEF.md
# Credit-Limited Macroblock Dispatcher

This block reads a stored 4:2:0 picture of 11 by 9 macroblocks (176x144 luma) out of a byte-wide frame memory. It hands the picture to a downstream transform pipeline one macroblock at a time, moving across each row of macroblocks and then down to the next row. Each macroblock leaves as 384 beats on a valid/ready stream. A beat carries one sample widened to 16 bits, the macroblock's column and row, and a coded-block-pattern header field.

The pipeline can hold only so many macroblocks at once. A credit counter starts full and loses one credit each time a macroblock is issued. The end of the pipeline returns one credit with each single-cycle acknowledge. While no credit is left, the dispatcher parks and waits for the next acknowledge. A single-cycle pulse on the frame-start input begins a picture. A single-cycle frame-done output marks that the last beat of the picture has been taken.

Top module: `mb_dispatch`

## Requirements
- R1: During and directly after reset, `out_valid`, `mem_rd` and `frame_done` are all low. The credit counter holds its full value of 5.
- R2: A picture is issued as 99 macroblocks in order. The column tag runs from 0 to 10. After column 10 it returns to 0 and the row tag advances, running from 0 to 8.
- R3: Within a macroblock, beats come in this order: the four 8x8 luma blocks (upper-left, upper-right, lower-left, lower-right), then the 8x8 Cb block, then the 8x8 Cr block. Each block is read row by row. Luma byte (x,y) sits at address y*176+x. Cb byte (x,y) sits at 25344+y*88+x. Cr byte (x,y) sits at 31680+y*88+x.
- R4: Each sample is the 8-bit memory byte, zero-extended to 16 bits. The read data comes back one cycle after `mem_rd`. The coded-block-pattern field is zero on every beat.
- R5: If no acknowledge arrives, at most 5 macroblocks (1920 beats) leave after frame start. The stream then stops with `out_valid` low.
- R6: Each `mb_ack` pulse returns one credit, which allows one more macroblock. Acknowledges count while idle and while streaming. The counter saturates at 5, so extra acknowledges never allow more than 5 outstanding macroblocks.
- R7: While `out_valid` is high and `out_ready` is low, the sample and both coordinate tags hold their values and `out_valid` stays high.
- R8: `frame_done` is high for exactly one cycle. That cycle directly follows the clock edge at which the last beat of macroblock (10,8) is accepted.
- R9: A frame-start pulse that arrives while a picture is still being issued or drained does not restart or disturb that picture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Single-cycle request to issue a picture |
| mb_ack | input | 1 | Single-cycle acknowledge that returns one credit |
| mem_rd | output | 1 | Frame memory read strobe |
| mem_addr | output | 16 | Frame memory byte address |
| mem_data | input | 8 | Read byte, valid one cycle after `mem_rd` |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_sample | output | 16 | Zero-extended sample |
| out_col | output | 4 | Macroblock column of the beat |
| out_row | output | 4 | Macroblock row of the beat |
| out_cbp | output | 6 | Coded-block-pattern header field |
| frame_done | output | 1 | One-cycle pulse after the last beat of the picture |

## Verification
The bench builds the block with its default parameters: 11 by 9 macroblocks and 5 credits. With these values the column wrap at 10, the last row at 8, and the chroma base offsets all fall inside one full picture of 38016 beats, so every address boundary is exercised. Five credits are few enough that the stall after 1920 beats, the saturation after extra acknowledges, and the one-credit-per-acknowledge restart can each be observed and counted at the output. A second picture runs under irregular back-pressure, which exercises the hold and read-ahead paths.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
    localparam int MB_PX          = 16;
    localparam int BLK_PX         = 8;
    localparam int SAMPLES_PER_MB = 384;
    localparam int IDX_W          = $clog2(SAMPLES_PER_MB);
    localparam int PIX_W          = 8;
    localparam int SAMPLE_W       = 16;
    localparam int CBP_W          = 6;
    localparam int FIFO_DEPTH     = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_WAIT_CREDIT,
        ST_FLUSH
    } walk_state_e;

    function automatic logic [SAMPLE_W-1:0] widen_pixel(input logic [PIX_W-1:0] p);
        return {{(SAMPLE_W-PIX_W){1'b0}}, p};
    endfunction
endpackage

// File: rtl/mbd_credit.sv
module mbd_credit #(
    parameter int MAX_CREDITS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic give,
    output logic avail
);
    localparam int CW = $clog2(MAX_CREDITS + 1);
    localparam logic [CW-1:0] FULL = CW'(MAX_CREDITS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= FULL;
        end else begin
            case ({take, give})
                2'b10:   cnt <= cnt - 1'b1;
                2'b01:   if (cnt != FULL) cnt <= cnt + 1'b1;
                default: ;
            endcase
        end
    end

    assign avail = (cnt != '0);

    assert_credit_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        take |-> (cnt != '0));
endmodule

// File: rtl/mbd_addr_gen.sv
module mbd_addr_gen
    import mbd_pkg::*;
#(
    parameter int MB_COLS = 11,
    parameter int MB_ROWS = 9,
    parameter int ADDR_W  = 16,
    parameter int COL_W   = 4,
    parameter int ROW_W   = 4
) (
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  row,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int LUMA_W    = MB_COLS * MB_PX;
    localparam int LUMA_SIZE = LUMA_W * MB_ROWS * MB_PX;
    localparam int CHR_W     = MB_COLS * BLK_PX;
    localparam int CHR_SIZE  = CHR_W * MB_ROWS * BLK_PX;

    logic [2:0] blk, br, bc;
    logic [ADDR_W-1:0] lx, ly, cx, cy, luma_a, chr_a;

    always_comb begin
        blk = idx[8:6];
        br  = idx[5:3];
        bc  = idx[2:0];
        lx  = ADDR_W'(col) * ADDR_W'(MB_PX) + (blk[0] ? ADDR_W'(BLK_PX) : '0) + ADDR_W'(bc);
        ly  = ADDR_W'(row) * ADDR_W'(MB_PX) + (blk[1] ? ADDR_W'(BLK_PX) : '0) + ADDR_W'(br);
        cx  = ADDR_W'(col) * ADDR_W'(BLK_PX) + ADDR_W'(bc);
        cy  = ADDR_W'(row) * ADDR_W'(BLK_PX) + ADDR_W'(br);
        luma_a = ly * ADDR_W'(LUMA_W) + lx;
        chr_a  = ADDR_W'(LUMA_SIZE) + (blk[0] ? ADDR_W'(CHR_SIZE) : '0)
                 + cy * ADDR_W'(CHR_W) + cx;
        addr = blk[2] ? chr_a : luma_a;
    end
endmodule

// File: rtl/mbd_beat_fifo.sv
module mbd_beat_fifo
    import mbd_pkg::*;
#(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         valid,
    output logic [1:0]   count
);
    logic [W-1:0] slot0, slot1;
    logic [1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case ({push, pop})
                2'b10: begin
                    if (cnt == 2'd0) slot0 <= din;
                    else             slot1 <= din;
                    cnt <= cnt + 2'd1;
                end
                2'b01: begin
                    slot0 <= slot1;
                    cnt   <= cnt - 2'd1;
                end
                2'b11: begin
                    if (cnt == 2'd1) begin
                        slot0 <= din;
                    end else begin
                        slot0 <= slot1;
                        slot1 <= din;
                    end
                end
                default: ;
            endcase
        end
    end

    assign head  = slot0;
    assign valid = (cnt != 2'd0);
    assign count = cnt;

    assert_fifo_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        push |-> ((cnt < 2'(FIFO_DEPTH)) || pop));
endmodule

// File: rtl/mb_dispatch.sv
module mb_dispatch
    import mbd_pkg::*;
#(
    parameter int MB_COLS = 11,
    parameter int MB_ROWS = 9,
    parameter int CREDITS = 5,
    localparam int FRAME_BYTES = MB_COLS * MB_ROWS * SAMPLES_PER_MB,
    localparam int ADDR_W = $clog2(FRAME_BYTES),
    localparam int COL_W  = (MB_COLS > 1) ? $clog2(MB_COLS) : 1,
    localparam int ROW_W  = (MB_ROWS > 1) ? $clog2(MB_ROWS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                mb_ack,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [PIX_W-1:0]    mem_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic [COL_W-1:0]    out_col,
    output logic [ROW_W-1:0]    out_row,
    output logic [CBP_W-1:0]    out_cbp,
    output logic                frame_done
);
    localparam int BEAT_W = PIX_W + COL_W + ROW_W + 1;

    walk_state_e       state;
    logic [COL_W-1:0]  col, pend_col, head_col;
    logic [ROW_W-1:0]  row, pend_row, head_row;
    logic [IDX_W-1:0]  idx;
    logic              rd_pend, pend_last, head_last;
    logic [PIX_W-1:0]  head_pix;
    logic [BEAT_W-1:0] fifo_din, fifo_head;
    logic [1:0]        fifo_cnt;
    logic [2:0]        occ;
    logic              pop, rd_ok, take, avail;
    logic              last_sample, last_col, last_row;

    mbd_credit #(.MAX_CREDITS(CREDITS)) u_credit (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .give  (mb_ack),
        .avail (avail)
    );

    mbd_addr_gen #(
        .MB_COLS (MB_COLS),
        .MB_ROWS (MB_ROWS),
        .ADDR_W  (ADDR_W),
        .COL_W   (COL_W),
        .ROW_W   (ROW_W)
    ) u_addr (
        .col  (col),
        .row  (row),
        .idx  (idx),
        .addr (mem_addr)
    );

    assign fifo_din = {mem_data, pend_col, pend_row, pend_last};

    mbd_beat_fifo #(.W(BEAT_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (rd_pend),
        .din   (fifo_din),
        .pop   (pop),
        .head  (fifo_head),
        .valid (out_valid),
        .count (fifo_cnt)
    );

    assign {head_pix, head_col, head_row, head_last} = fifo_head;
    assign out_sample = widen_pixel(head_pix);
    assign out_col    = head_col;
    assign out_row    = head_row;
    assign out_cbp    = '0;

    always_comb begin
        pop         = out_valid && out_ready;
        occ         = {1'b0, fifo_cnt} + {2'b00, rd_pend};
        rd_ok       = (occ < 3'd2) || pop;
        mem_rd      = (state == ST_STREAM) && rd_ok;
        last_sample = (idx == IDX_W'(SAMPLES_PER_MB - 1));
        last_col    = (col == COL_W'(MB_COLS - 1));
        last_row    = (row == ROW_W'(MB_ROWS - 1));
        take        = avail && (((state == ST_IDLE) && frame_start)
                              || (state == ST_WAIT_CREDIT)
                              || (mem_rd && last_sample && !(last_col && last_row)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            col   <= '0;
            row   <= '0;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (frame_start) begin
                        col   <= '0;
                        row   <= '0;
                        idx   <= '0;
                        state <= avail ? ST_STREAM : ST_WAIT_CREDIT;
                    end
                end
                ST_STREAM: begin
                    if (mem_rd) begin
                        if (!last_sample) begin
                            idx <= idx + 1'b1;
                        end else begin
                            idx <= '0;
                            if (last_col && last_row) begin
                                state <= ST_FLUSH;
                            end else begin
                                if (last_col) begin
                                    col <= '0;
                                    row <= row + 1'b1;
                                end else begin
                                    col <= col + 1'b1;
                                end
                                state <= avail ? ST_STREAM : ST_WAIT_CREDIT;
                            end
                        end
                    end
                end
                ST_WAIT_CREDIT: begin
                    if (avail) state <= ST_STREAM;
                end
                ST_FLUSH: begin
                    if (pop && head_last) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend    <= 1'b0;
            pend_col   <= '0;
            pend_row   <= '0;
            pend_last  <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            rd_pend    <= mem_rd;
            pend_col   <= col;
            pend_row   <= row;
            pend_last  <= last_sample && last_col && last_row;
            frame_done <= pop && head_last;
        end
    end

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)
                                       && $stable(out_col) && $stable(out_row)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    assert_addr_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr < ADDR_W'(FRAME_BYTES)));

    assert_restart_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_STREAM) && frame_start && !mem_rd) |=> $stable(idx));
endmodule

// File: tb/mb_dispatch_bench.sv
module mb_dispatch_bench;
    import mbd_pkg::*;

    localparam int COLS = 11;
    localparam int ROWS = 9;

    typedef struct packed {
        logic [15:0] smp;
        logic [3:0]  col;
        logic [3:0]  row;
        logic        last_mb;
        logic        last_frame;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start;
    logic        ack_man, ack_auto;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_sample;
    logic [3:0]  out_col, out_row;
    logic [5:0]  out_cbp;
    logic        frame_done;

    int   checks = 0;
    int   errors = 0;
    int   accepted = 0;
    int   done_count = 0;
    bit   rdy_mode = 0;
    bit   auto_ack_en = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    mb_dispatch u_mb_dispatch (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .mb_ack      (ack_man | ack_auto),
        .mem_rd      (mem_rd),
        .mem_addr    (mem_addr),
        .mem_data    (mem_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_sample  (out_sample),
        .out_col     (out_col),
        .out_row     (out_row),
        .out_cbp     (out_cbp),
        .frame_done  (frame_done)
    );

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 7) ^ (a >> 8));
    endfunction

    always @(posedge clk) if (mem_rd) mem_data <= mem_byte(int'(mem_addr));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic push_frame();
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                for (int s = 0; s < 384; s++) begin
                    int b  = s / 64;
                    int yy = (s / 8) % 8;
                    int xx = s % 8;
                    int a;
                    exp_t e;
                    if (b < 4) a = (r * 16 + (b / 2) * 8 + yy) * 176 + c * 16 + (b % 2) * 8 + xx;
                    else       a = 25344 + ((b == 5) ? 6336 : 0) + (r * 8 + yy) * 88 + c * 8 + xx;
                    e.smp        = {8'h00, mem_byte(a)};
                    e.col        = 4'(c);
                    e.row        = 4'(r);
                    e.last_mb    = (s == 383);
                    e.last_frame = (s == 383) && (c == COLS - 1) && (r == ROWS - 1);
                    exp_q.push_back(e);
                end
            end
        end
    endtask

    task automatic pulse_ack();
        @(negedge clk) ack_man = 1'b1;
        @(negedge clk) ack_man = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    // scoreboard monitor: decides ready, then compares the beat that the next edge accepts
    logic [15:0] lfsr = 16'hACE1;
    bit          stall_prev = 0;
    bit          exp_done = 0;
    logic [15:0] prev_smp;
    logic [3:0]  prev_col, prev_row;

    always @(negedge clk) begin : monitor
        exp_t e;
        if (rst) begin
            out_ready = 1'b0;
            ack_auto  = 1'b0;
        end else begin
            if (exp_done || frame_done) begin
                check(frame_done == exp_done, "R8", "frame_done", frame_done, exp_done);
                if (frame_done) done_count++;
            end
            exp_done = 0;
            if (stall_prev) begin
                check(out_valid && out_sample == prev_smp, "R7", "held sample", out_sample, prev_smp);
                check(out_col == prev_col && out_row == prev_row, "R7", "held tags",
                      {out_row, out_col}, {prev_row, prev_col});
            end
            if (!rdy_mode) begin
                out_ready = 1'b1;
            end else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                out_ready = (lfsr[1:0] != 2'b00);
            end
            ack_auto = 1'b0;
            if (out_valid && out_ready) begin
                accepted++;
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected beat", accepted, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(out_sample == e.smp, "R3", "sample", out_sample, e.smp);
                    check(out_col == e.col && out_row == e.row, "R2", "tags",
                          {out_row, out_col}, {e.row, e.col});
                    check(out_cbp == 6'd0, "R4", "cbp", out_cbp, 0);
                    if (e.last_mb && auto_ack_en) ack_auto = 1'b1;
                    if (e.last_frame) exp_done = 1;
                end
            end
            stall_prev = out_valid && !out_ready;
            prev_smp   = out_sample;
            prev_col   = out_col;
            prev_row   = out_row;
        end
    end

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        check(0, "R2", "watchdog expired", accepted, 76032);
        report();
    end

    initial begin : driver
        rst = 1'b1;
        frame_start = 1'b0;
        ack_man = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(mem_rd == 1'b0, "R1", "mem_rd after reset", mem_rd, 0);
        check(frame_done == 1'b0, "R1", "frame_done after reset", frame_done, 0);

        // R6: acks while idle must saturate at the full credit count
        repeat (3) pulse_ack();
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R1", "idle without frame start", out_valid, 0);

        push_frame();
        pulse_start();
        wait (accepted == 1920);
        repeat (400) @(negedge clk);
        // R5: five macroblocks only, then stall
        check(accepted == 1920, "R5", "beats before stall", accepted, 1920);
        check(out_valid == 1'b0, "R5", "valid during stall", out_valid, 0);

        // R6: one acknowledge, one macroblock
        pulse_ack();
        wait (accepted == 2304);
        repeat (400) @(negedge clk);
        check(accepted == 2304, "R6", "beats after one ack", accepted, 2304);

        auto_ack_en = 1;
        pulse_ack();
        wait (accepted >= 10000);
        pulse_start();  // R9: must not restart the picture
        wait (exp_q.size() == 0);
        repeat (5) @(negedge clk);
        check(accepted == 38016, "R9", "beats in first picture", accepted, 38016);
        check(done_count == 1, "R8", "done pulses after first picture", done_count, 1);

        // second picture under irregular back-pressure
        repeat (6) pulse_ack();
        rdy_mode = 1;
        push_frame();
        pulse_start();
        wait (exp_q.size() == 0);
        repeat (10) @(negedge clk);
        check(accepted == 76032, "R2", "beats after second picture", accepted, 76032);
        check(done_count == 2, "R8", "done pulses after second picture", done_count, 2);
        check(out_valid == 1'b0, "R2", "valid after picture", out_valid, 0);
        report();
    end
endmodule